// File: doc/BRIEF.md
# Page Access Permission Checker

This block decides whether one memory access may go ahead, once a page-table walk has fetched the entries that map it. It takes the kind of access (read, write or instruction fetch) and the privilege context. The context is one of three: user, supervisor, or supervisor with the user-data guard waived. It also takes the page-size kind, the directory entry, the table entry and a small set of control bits. From these it returns a protection-fault flag, the bits of the page-fault error code, and a request to write back the accessed and dirty flags of the leaf entry.

Two supervisor guards are built in. The fetch guard stops supervisor code from running out of user-owned pages. The data guard stops supervisor reads and writes to user-owned pages, except in the override context. A no-execute bit in each entry is honoured only while its enable is on. The fetch bit of the error code is also reported whenever the fetch guard is on, so a handler can see a fetch fault even when no-execute is disabled.

Each request is captured in an input register when `in_valid` is high. The decision is made by combinational logic and lands in an output register one clock later. The result therefore appears two clocks after the request.

Top module: `page_perm_check`

## Requirements
- R1: `out_valid` equals `in_valid` from two clock edges earlier. A synchronous active-low reset clears `out_valid`, `prot_fault`, `err_code`, `leaf_upd` and `leaf_dirty` to zero.
- R2: An instruction fetch (`acc_kind`=2) faults in every privilege context when the effective no-execute bit is set. That bit sits at position ENTRY_W-1. For a small page it is the OR of the directory and table bits, and for a large page it is the directory bit alone. It counts as zero whenever `ctl_nx_en` is low.
- R3: In the user context (`priv_idx`=0), an access faults if the effective user bit (bit 2) is clear. A write (`acc_kind`=1) also faults if the effective writable bit (bit 1) is clear.
- R4: In the plain supervisor context (`priv_idx`=1), a read or write to a page whose effective user bit is set faults when `ctl_data_guard` is high.
- R5: In both supervisor contexts (`priv_idx`=1 or 2), a fetch from a page whose effective user bit is set faults when `ctl_fetch_guard` is high. The override context (`priv_idx`=2) never applies the R4 check.
- R6: In both supervisor contexts, a write to a page whose effective writable bit is clear faults only when `ctl_wr_protect` is high.
- R7: A mid-size request (`page_kind`=1) is a large page when the directory size bit (bit 7) is set. A big request (`page_kind`=2) is a large page only when bit 7 is set and `ctl_large_en` is high. A large page takes its user and writable bits from the directory entry alone. Every other case is a small page, whose user and writable bits are the AND of the directory and table entries.
- R8: The error code is built from these bits:
  - bit 0: the fault flag.
  - bit 1: set for a write.
  - bit 2: set for the user context.
  - bit 3: always zero.
  - bit 4: set for a fetch when either (`ctl_nx_en` and `ctl_wide_en` are both high) or `ctl_fetch_guard` is high.
- R9: The leaf entry is the table entry for a small page and the directory entry for a large one. `leaf_upd` is high when there is no fault and either the leaf accessed bit (bit 5) is clear, or the access is a write and the leaf dirty bit (bit 6) is clear. `leaf_dirty` is high for a write that does not fault.
- R10: A clock edge whose input register holds no valid request leaves `prot_fault`, `err_code`, `leaf_upd` and `leaf_dirty` unchanged and drives `out_valid` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Request present this cycle |
| acc_kind | input | 2 | 0 read, 1 write, 2 fetch |
| priv_idx | input | 2 | 0 user, 1 supervisor, 2 supervisor with data guard waived |
| page_kind | input | 2 | 0 small, 1 mid-size, 2 big |
| dir_entry | input | ENTRY_W | Directory entry from the walk |
| tbl_entry | input | ENTRY_W | Table entry from the walk |
| ctl_wr_protect | input | 1 | Supervisor writes obey the writable bit |
| ctl_fetch_guard | input | 1 | Supervisor fetch from user pages is blocked |
| ctl_data_guard | input | 1 | Supervisor data access to user pages is blocked |
| ctl_nx_en | input | 1 | No-execute bit is honoured |
| ctl_wide_en | input | 1 | Wide entry format is active |
| ctl_large_en | input | 1 | Big pages are allowed |
| out_valid | output | 1 | Result present |
| prot_fault | output | 1 | Access is refused |
| err_code | output | ERR_W | Page-fault error code |
| leaf_upd | output | 1 | Write back the accessed/dirty flags of the leaf |
| leaf_dirty | output | 1 | The write-back also sets the dirty flag |

## Verification
The bench builds the block with its defaults: 64-bit entries, no-execute support present with the no-execute bit at position 63, and a five-bit error code. With these values the no-execute path and the fetch bit of the error code can both be observed. A full sweep crosses every access kind, privilege context and page kind with twelve entry and control bits, and covers the fallback from big to small pages. Requests enter back to back in the sweep, so the two-stage timing is exercised at full rate. Directed tests cover reset and the hold of results on idle cycles.

// File: rtl/page_perm_pkg.sv
// Shared encodings for the page access permission checker.
// Assumes: two-bit codes for access kind, privilege context and page kind.
package page_perm_pkg;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_FETCH = 2'd2,
        ACC_NONE  = 2'd3
    } acc_kind_e;

    typedef enum logic [1:0] {
        PRV_USER    = 2'd0,
        PRV_SUP     = 2'd1,
        PRV_SUP_OVR = 2'd2,
        PRV_NONE    = 2'd3
    } priv_e;

    typedef enum logic [1:0] {
        PGK_SMALL = 2'd0,
        PGK_MID   = 2'd1,
        PGK_BIG   = 2'd2,
        PGK_NONE  = 2'd3
    } page_kind_e;

    typedef struct packed {
        logic wr_protect;
        logic fetch_guard;
        logic data_guard;
        logic nx_en;
        logic wide_en;
        logic large_en;
    } ctl_t;

    typedef struct packed {
        logic user;
        logic writable;
        logic no_exec;
    } perm_t;

    typedef struct packed {
        logic accessed;
        logic dirty;
    } leaf_t;

    localparam int ERR_PRESENT = 0;
    localparam int ERR_WRITE   = 1;
    localparam int ERR_USER    = 2;
    localparam int ERR_FETCH   = 4;
    localparam int ERR_MIN_W   = 5;

endpackage

// File: rtl/ppc_in_stage.sv
// Input register of the checker: captures one request per valid cycle.
// Assumes: the request fields are stable while in_valid is high.
module ppc_in_stage
    import page_perm_pkg::*;
#(
    parameter int ENTRY_W = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  acc_kind_e          acc_i,
    input  priv_e              priv_i,
    input  page_kind_e         kind_i,
    input  logic [ENTRY_W-1:0] dir_i,
    input  logic [ENTRY_W-1:0] tbl_i,
    input  ctl_t               ctl_i,
    output logic               st_valid,
    output acc_kind_e          st_acc,
    output priv_e              st_priv,
    output page_kind_e         st_kind,
    output logic [ENTRY_W-1:0] st_dir,
    output logic [ENTRY_W-1:0] st_tbl,
    output ctl_t               st_ctl
);

    // Track whether the register holds a request.
    always_ff @(posedge clk) begin
        if (!rst_n) st_valid <= 1'b0;
        else        st_valid <= in_valid;
    end

    // Load the request bundle on a valid cycle only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_acc  <= ACC_READ;
            st_priv <= PRV_USER;
            st_kind <= PGK_SMALL;
            st_dir  <= '0;
            st_tbl  <= '0;
            st_ctl  <= '0;
        end else if (in_valid) begin
            st_acc  <= acc_i;
            st_priv <= priv_i;
            st_kind <= kind_i;
            st_dir  <= dir_i;
            st_tbl  <= tbl_i;
            st_ctl  <= ctl_i;
        end
    end

endmodule

// File: rtl/ppc_entry_merge.sv
// Combines directory and table entries into effective permissions and
// picks the leaf entry whose flags may be written back.
// Assumes: bit positions are the same in both entry levels.
module ppc_entry_merge
    import page_perm_pkg::*;
#(
    parameter int ENTRY_W   = 64,
    parameter int RW_POS    = 1,
    parameter int US_POS    = 2,
    parameter int ACC_POS   = 5,
    parameter int DIRTY_POS = 6,
    parameter int PS_POS    = 7,
    parameter int NX_POS    = ENTRY_W - 1,
    parameter bit HAS_NX    = 1'b1
) (
    input  page_kind_e         kind_i,
    input  logic [ENTRY_W-1:0] dir_i,
    input  logic [ENTRY_W-1:0] tbl_i,
    input  ctl_t               ctl_i,
    output perm_t              eff_o,
    output leaf_t              leaf_o,
    output logic               large_o
);

    localparam int N_LANES = 2;
    localparam int LANE_POS [N_LANES] = '{US_POS, RW_POS};

    logic               is_large;
    logic [N_LANES-1:0] lane;
    logic               nx_raw;
    logic               unused_merge;

    // Decide whether the directory entry maps the page by itself.
    always_comb begin
        is_large = 1'b0;
        if (kind_i == PGK_MID)
            is_large = dir_i[PS_POS];
        else if (kind_i == PGK_BIG)
            is_large = dir_i[PS_POS] & ctl_i.large_en;
    end

    // One lane per permission bit: directory alone or AND of both levels.
    for (genvar g = 0; g < N_LANES; g++) begin : g_lane
        assign lane[g] = is_large ? dir_i[LANE_POS[g]]
                                  : (dir_i[LANE_POS[g]] & tbl_i[LANE_POS[g]]);
    end

    // No-execute source exists only when the entry format carries it.
    if (HAS_NX) begin : g_nx
        assign nx_raw = is_large ? dir_i[NX_POS] : (dir_i[NX_POS] | tbl_i[NX_POS]);
    end else begin : g_no_nx
        assign nx_raw = 1'b0;
    end

    // Assemble effective permissions and leaf flags.
    always_comb begin
        eff_o.user      = lane[0];
        eff_o.writable  = lane[1];
        eff_o.no_exec   = nx_raw & ctl_i.nx_en;
        leaf_o.accessed = is_large ? dir_i[ACC_POS]   : tbl_i[ACC_POS];
        leaf_o.dirty    = is_large ? dir_i[DIRTY_POS] : tbl_i[DIRTY_POS];
        large_o         = is_large;
    end

    assign unused_merge = ^{dir_i, tbl_i, ctl_i};

endmodule

// File: rtl/ppc_rule_eval.sv
// Applies the access rules of each privilege context to the effective
// permissions and raises the protection-fault flag.
// Assumes: effective no-execute is already masked by its enable.
module ppc_rule_eval
    import page_perm_pkg::*;
(
    input  acc_kind_e acc_i,
    input  priv_e     priv_i,
    input  perm_t     eff_i,
    input  ctl_t      ctl_i,
    output logic      fault_o
);

    logic is_fetch;
    logic is_write;
    logic nx_hit;
    logic user_hit;
    logic data_hit;
    logic sup_hit;
    logic ctx_hit;
    logic unused_rule;

    // Classify the access.
    always_comb begin
        is_fetch = (acc_i == ACC_FETCH);
        is_write = (acc_i == ACC_WRITE);
    end

    // Evaluate each rule independently.
    always_comb begin
        nx_hit   = is_fetch & eff_i.no_exec;
        user_hit = ~eff_i.user | (is_write & ~eff_i.writable);
        data_hit = ~is_fetch & ctl_i.data_guard & eff_i.user;
        sup_hit  = (is_fetch & ctl_i.fetch_guard & eff_i.user)
                 | (ctl_i.wr_protect & is_write & ~eff_i.writable);
    end

    // Select the rules that belong to the privilege context.
    always_comb begin
        unique case (priv_i)
            PRV_USER:    ctx_hit = user_hit;
            PRV_SUP:     ctx_hit = data_hit | sup_hit;
            PRV_SUP_OVR: ctx_hit = sup_hit;
            default:     ctx_hit = 1'b0;
        endcase
        fault_o = nx_hit | ctx_hit;
    end

    assign unused_rule = ^ctl_i;

endmodule

// File: rtl/ppc_err_encode.sv
// Builds the page-fault error code and the leaf write-back request.
// Assumes: ERR_W is at least the package minimum width.
module ppc_err_encode
    import page_perm_pkg::*;
#(
    parameter int ERR_W = ERR_MIN_W
) (
    input  acc_kind_e        acc_i,
    input  priv_e            priv_i,
    input  ctl_t             ctl_i,
    input  logic             fault_i,
    input  leaf_t            leaf_i,
    output logic [ERR_W-1:0] err_o,
    output logic             upd_o,
    output logic             dirty_o
);

    logic is_fetch;
    logic is_write;
    logic fetch_rep;
    logic unused_enc;

    // Decide when a fetch is reported in the error code.
    always_comb begin
        is_fetch  = (acc_i == ACC_FETCH);
        is_write  = (acc_i == ACC_WRITE);
        fetch_rep = is_fetch & ((ctl_i.nx_en & ctl_i.wide_en) | ctl_i.fetch_guard);
    end

    // Pack the error code bits.
    always_comb begin
        err_o              = '0;
        err_o[ERR_PRESENT] = fault_i;
        err_o[ERR_WRITE]   = is_write;
        err_o[ERR_USER]    = (priv_i == PRV_USER);
        err_o[ERR_FETCH]   = fetch_rep;
    end

    // Request flag write-back only for an allowed access.
    always_comb begin
        upd_o   = ~fault_i & (~leaf_i.accessed | (is_write & ~leaf_i.dirty));
        dirty_o = ~fault_i & is_write;
    end

    assign unused_enc = ^ctl_i;

endmodule

// File: rtl/page_perm_check.sv
// Top of the page access permission checker: input register, combinational
// decision, output register; results appear two clocks after a request.
// Assumes: the walk has already found both entries present.
module page_perm_check
    import page_perm_pkg::*;
#(
    parameter int ENTRY_W   = 64,
    parameter int ERR_W     = 5,
    parameter int RW_POS    = 1,
    parameter int US_POS    = 2,
    parameter int ACC_POS   = 5,
    parameter int DIRTY_POS = 6,
    parameter int PS_POS    = 7,
    parameter int NX_POS    = ENTRY_W - 1,
    parameter bit HAS_NX    = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [1:0]         acc_kind,
    input  logic [1:0]         priv_idx,
    input  logic [1:0]         page_kind,
    input  logic [ENTRY_W-1:0] dir_entry,
    input  logic [ENTRY_W-1:0] tbl_entry,
    input  logic               ctl_wr_protect,
    input  logic               ctl_fetch_guard,
    input  logic               ctl_data_guard,
    input  logic               ctl_nx_en,
    input  logic               ctl_wide_en,
    input  logic               ctl_large_en,
    output logic               out_valid,
    output logic               prot_fault,
    output logic [ERR_W-1:0]   err_code,
    output logic               leaf_upd,
    output logic               leaf_dirty
);

    ctl_t               ctl_in;
    logic               st_valid;
    acc_kind_e          st_acc;
    priv_e              st_priv;
    page_kind_e         st_kind;
    logic [ENTRY_W-1:0] st_dir;
    logic [ENTRY_W-1:0] st_tbl;
    ctl_t               st_ctl;
    perm_t              eff_perm;
    leaf_t              leaf_flags;
    logic               is_large;
    logic               fault_c;
    logic [ERR_W-1:0]   err_c;
    logic               upd_c;
    logic               dirty_c;
    logic               unused_top;

    // Gather the control pins into one bundle.
    always_comb begin
        ctl_in.wr_protect  = ctl_wr_protect;
        ctl_in.fetch_guard = ctl_fetch_guard;
        ctl_in.data_guard  = ctl_data_guard;
        ctl_in.nx_en       = ctl_nx_en;
        ctl_in.wide_en     = ctl_wide_en;
        ctl_in.large_en    = ctl_large_en;
    end

    ppc_in_stage #(.ENTRY_W(ENTRY_W)) u_in (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .acc_i    (acc_kind_e'(acc_kind)),
        .priv_i   (priv_e'(priv_idx)),
        .kind_i   (page_kind_e'(page_kind)),
        .dir_i    (dir_entry),
        .tbl_i    (tbl_entry),
        .ctl_i    (ctl_in),
        .st_valid (st_valid),
        .st_acc   (st_acc),
        .st_priv  (st_priv),
        .st_kind  (st_kind),
        .st_dir   (st_dir),
        .st_tbl   (st_tbl),
        .st_ctl   (st_ctl)
    );

    ppc_entry_merge #(
        .ENTRY_W   (ENTRY_W),
        .RW_POS    (RW_POS),
        .US_POS    (US_POS),
        .ACC_POS   (ACC_POS),
        .DIRTY_POS (DIRTY_POS),
        .PS_POS    (PS_POS),
        .NX_POS    (NX_POS),
        .HAS_NX    (HAS_NX)
    ) u_merge (
        .kind_i  (st_kind),
        .dir_i   (st_dir),
        .tbl_i   (st_tbl),
        .ctl_i   (st_ctl),
        .eff_o   (eff_perm),
        .leaf_o  (leaf_flags),
        .large_o (is_large)
    );

    ppc_rule_eval u_rule (
        .acc_i   (st_acc),
        .priv_i  (st_priv),
        .eff_i   (eff_perm),
        .ctl_i   (st_ctl),
        .fault_o (fault_c)
    );

    ppc_err_encode #(.ERR_W(ERR_W)) u_enc (
        .acc_i   (st_acc),
        .priv_i  (st_priv),
        .ctl_i   (st_ctl),
        .fault_i (fault_c),
        .leaf_i  (leaf_flags),
        .err_o   (err_c),
        .upd_o   (upd_c),
        .dirty_o (dirty_c)
    );

    // Output register: valid follows the input stage, results load on valid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            prot_fault <= 1'b0;
            err_code   <= '0;
            leaf_upd   <= 1'b0;
            leaf_dirty <= 1'b0;
        end else begin
            out_valid <= st_valid;
            if (st_valid) begin
                prot_fault <= fault_c;
                err_code   <= err_c;
                leaf_upd   <= upd_c;
                leaf_dirty <= dirty_c;
            end
        end
    end

    assign unused_top = is_large;

endmodule

// File: rtl/ppc_checker.sv
// Property checker for the permission checker, bound to its top module.
// Assumes: one input-register stage and one output-register stage.
module ppc_checker
    import page_perm_pkg::*;
#(
    parameter int ERR_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             st_valid,
    input acc_kind_e        st_acc,
    input priv_e            st_priv,
    input ctl_t             st_ctl,
    input perm_t            eff,
    input logic             out_valid,
    input logic             prot_fault,
    input logic [ERR_W-1:0] err_code,
    input logic             leaf_upd,
    input logic             leaf_dirty
);

    logic [1:0] since_rst;
    logic       unused_chk;

    // Count edges since reset so history is only used once it exists.
    always_ff @(posedge clk) begin
        if (!rst_n)                since_rst <= 2'd0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end

    AST_VALID_LAG: assert property (@(posedge clk) disable iff (!rst_n) (since_rst >= 2'd2) |-> (out_valid == $past(in_valid, 2))); // R1
    AST_NX_FETCH: assert property (@(posedge clk) disable iff (!rst_n) ((since_rst != 2'd0) && $past(st_valid && st_acc == ACC_FETCH && eff.no_exec)) |-> prot_fault); // R2
    AST_DATA_GUARD: assert property (@(posedge clk) disable iff (!rst_n) ((since_rst != 2'd0) && $past(st_valid && st_priv == PRV_SUP && (st_acc == ACC_READ || st_acc == ACC_WRITE) && st_ctl.data_guard && eff.user)) |-> prot_fault); // R4
    AST_FETCH_GUARD: assert property (@(posedge clk) disable iff (!rst_n) ((since_rst != 2'd0) && $past(st_valid && (st_priv == PRV_SUP || st_priv == PRV_SUP_OVR) && st_acc == ACC_FETCH && st_ctl.fetch_guard && eff.user)) |-> prot_fault); // R5
    AST_WP_OFF: assert property (@(posedge clk) disable iff (!rst_n) ((since_rst != 2'd0) && $past(st_valid && st_priv == PRV_SUP_OVR && st_acc == ACC_WRITE && !st_ctl.wr_protect)) |-> !prot_fault); // R6
    AST_ERR_USER: assert property (@(posedge clk) disable iff (!rst_n) ((since_rst != 2'd0) && out_valid) |-> (err_code[ERR_USER] == $past(st_priv == PRV_USER))); // R8
    AST_NO_UPD_ON_FAULT: assert property (@(posedge clk) disable iff (!rst_n) (out_valid && prot_fault) |-> (!leaf_upd && !leaf_dirty)); // R9
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n) ((since_rst != 2'd0) && !$past(st_valid)) |-> (!out_valid && $stable({prot_fault, err_code, leaf_upd, leaf_dirty}))); // R10

    assign unused_chk = ^st_ctl;

endmodule

bind page_perm_check ppc_checker #(.ERR_W(ERR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .st_valid   (st_valid),
    .st_acc     (st_acc),
    .st_priv    (st_priv),
    .st_ctl     (st_ctl),
    .eff        (eff_perm),
    .out_valid  (out_valid),
    .prot_fault (prot_fault),
    .err_code   (err_code),
    .leaf_upd   (leaf_upd),
    .leaf_dirty (leaf_dirty)
);

// File: tb/sim_page_perm_check.sv
// Self-checking bench: a vector table, a full pipelined sweep against a
// reference model written from the requirements, then directed tests.
module sim_page_perm_check;

    localparam int CLK_PERIOD = 10;
    localparam int ENTRY_W    = 64;
    localparam int ERR_W      = 5;
    localparam int N_SWEEP    = 27 * 4096;
    localparam int WATCHDOG   = 190000;
    localparam int N_VEC      = 14;

    // {tag, acc, priv, kind, dir{us,rw,ps,nx,acc,dirty}, tbl{us,rw,nx,acc,dirty},
    //  ctl{wp,fg,dg,nxen,wide,large}, exp{fault,err[4:0],upd,dirty}}
    localparam logic [34:0] VEC [N_VEC] = '{
        {4'd3, 2'd0, 2'd0, 2'd0, 6'b110010, 5'b11011, 6'b000000, 8'b0_00100_0_0}, // R3 user read ok
        {4'd3, 2'd1, 2'd0, 2'd0, 6'b100010, 5'b11011, 6'b000000, 8'b1_00111_0_0}, // R3 user write to read-only
        {4'd3, 2'd0, 2'd0, 2'd0, 6'b110010, 5'b01011, 6'b000000, 8'b1_00101_0_0}, // R3 table user bit clear
        {4'd4, 2'd0, 2'd1, 2'd0, 6'b110010, 5'b11011, 6'b001000, 8'b1_00001_0_0}, // R4 data guard
        {4'd5, 2'd0, 2'd2, 2'd0, 6'b110010, 5'b11001, 6'b001000, 8'b0_00000_1_0}, // R5 override skips data guard
        {4'd5, 2'd2, 2'd2, 2'd0, 6'b110010, 5'b11011, 6'b010000, 8'b1_10001_0_0}, // R5 fetch guard
        {4'd2, 2'd2, 2'd1, 2'd0, 6'b010110, 5'b01011, 6'b000100, 8'b1_00001_0_0}, // R2 no-execute fetch
        {4'd2, 2'd2, 2'd1, 2'd0, 6'b010110, 5'b01011, 6'b000000, 8'b0_00000_0_0}, // R2 no-execute disabled
        {4'd6, 2'd1, 2'd1, 2'd0, 6'b000010, 5'b11010, 6'b000000, 8'b0_00010_1_1}, // R6 write protect off
        {4'd6, 2'd1, 2'd1, 2'd0, 6'b000010, 5'b11010, 6'b100000, 8'b1_00011_0_0}, // R6 write protect on
        {4'd7, 2'd1, 2'd0, 2'd2, 6'b111010, 5'b00000, 6'b000001, 8'b0_00110_1_1}, // R7 big page directory only
        {4'd7, 2'd1, 2'd0, 2'd2, 6'b111010, 5'b00000, 6'b000000, 8'b1_00111_0_0}, // R7 big page falls back
        {4'd7, 2'd2, 2'd0, 2'd1, 6'b111000, 5'b00100, 6'b000110, 8'b0_10100_1_0}, // R7 mid page ignores table nx
        {4'd8, 2'd2, 2'd0, 2'd0, 6'b110010, 5'b11011, 6'b010000, 8'b0_10100_0_0}  // R8 fetch bit via guard only
    };

    logic               clk = 1'b0;
    logic               rst_n;
    logic               in_valid;
    logic [1:0]         acc_kind;
    logic [1:0]         priv_idx;
    logic [1:0]         page_kind;
    logic [ENTRY_W-1:0] dir_entry;
    logic [ENTRY_W-1:0] tbl_entry;
    logic               ctl_wr_protect;
    logic               ctl_fetch_guard;
    logic               ctl_data_guard;
    logic               ctl_nx_en;
    logic               ctl_wide_en;
    logic               ctl_large_en;
    logic               out_valid;
    logic               prot_fault;
    logic [ERR_W-1:0]   err_code;
    logic               leaf_upd;
    logic               leaf_dirty;

    int checks = 0;
    int errors = 0;
    logic [7:0] exp_ring [3];

    always #(CLK_PERIOD / 2) clk = ~clk;

    page_perm_check #(.ENTRY_W(ENTRY_W), .ERR_W(ERR_W)) u0 (
        .clk (clk), .rst_n (rst_n), .in_valid (in_valid),
        .acc_kind (acc_kind), .priv_idx (priv_idx), .page_kind (page_kind),
        .dir_entry (dir_entry), .tbl_entry (tbl_entry),
        .ctl_wr_protect (ctl_wr_protect), .ctl_fetch_guard (ctl_fetch_guard),
        .ctl_data_guard (ctl_data_guard), .ctl_nx_en (ctl_nx_en),
        .ctl_wide_en (ctl_wide_en), .ctl_large_en (ctl_large_en),
        .out_valid (out_valid), .prot_fault (prot_fault), .err_code (err_code),
        .leaf_upd (leaf_upd), .leaf_dirty (leaf_dirty)
    );

    function automatic logic [ENTRY_W-1:0] mk_dir(input logic [5:0] d);
        logic [ENTRY_W-1:0] e = '0;
        e[0] = 1'b1; e[2] = d[5]; e[1] = d[4]; e[7] = d[3];
        e[ENTRY_W-1] = d[2]; e[5] = d[1]; e[6] = d[0];
        return e;
    endfunction

    function automatic logic [ENTRY_W-1:0] mk_tbl(input logic [4:0] t);
        logic [ENTRY_W-1:0] e = '0;
        e[0] = 1'b1; e[2] = t[4]; e[1] = t[3];
        e[ENTRY_W-1] = t[2]; e[5] = t[1]; e[6] = t[0];
        return e;
    endfunction

    // Reference model: returns {fault, err[4:0], upd, dirty}.
    function automatic logic [7:0] ref_eval(input int a, input int p, input int k,
                                            input logic [5:0] d, input logic [4:0] t,
                                            input logic [5:0] c);
        logic lg, us, rw, nx, lacc, ldty, f, fr;
        lg   = (k == 1 && d[3]) || (k == 2 && d[3] && c[0]);
        us   = lg ? d[5] : (d[5] & t[4]);
        rw   = lg ? d[4] : (d[4] & t[3]);
        nx   = c[2] & (lg ? d[2] : (d[2] | t[2]));
        lacc = lg ? d[1] : t[1];
        ldty = lg ? d[0] : t[0];
        f    = (a == 2) && nx;
        if (p == 0 && (!us || (a == 1 && !rw))) f = 1'b1;
        if (p == 1 && a != 2 && c[3] && us) f = 1'b1;
        if ((p == 1 || p == 2) && a == 2 && c[4] && us) f = 1'b1;
        if ((p == 1 || p == 2) && c[5] && a == 1 && !rw) f = 1'b1;
        fr = (a == 2) && ((c[2] & c[1]) | c[4]);
        return {f, fr, 1'b0, p == 0, a == 1, f,
                !f && (!lacc || (a == 1 && !ldty)), !f && a == 1};
    endfunction

    task automatic drive(input int a, input int p, input int k,
                         input logic [5:0] d, input logic [4:0] t, input logic [5:0] c);
        acc_kind  = 2'(a);
        priv_idx  = 2'(p);
        page_kind = 2'(k);
        dir_entry = mk_dir(d);
        tbl_entry = mk_tbl(t);
        {ctl_wr_protect, ctl_fetch_guard, ctl_data_guard,
         ctl_nx_en, ctl_wide_en, ctl_large_en} = c;
    endtask

    task automatic check_bit(input string tag, input logic got, input logic exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %b expected %b", tag, got, exp);
        end
    endtask

    // Compare the result fields; fault mismatches carry the vector's tag.
    task automatic check_result(input int ftag, input logic [7:0] exp);
        checks += 3;
        if (prot_fault !== exp[7]) begin
            errors++;
            $display("FAIL R%0d fault: got %b expected %b", ftag, prot_fault, exp[7]);
        end
        if (err_code !== exp[6:2]) begin
            errors++;
            $display("FAIL R8 err_code: got %b expected %b", err_code, exp[6:2]);
        end
        if ({leaf_upd, leaf_dirty} !== exp[1:0]) begin
            errors++;
            $display("FAIL R9 upd/dirty: got %b expected %b", {leaf_upd, leaf_dirty}, exp[1:0]);
        end
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rst_n    = 1'b0;
        in_valid = 1'b1;
        drive(1, 0, 0, 6'b100010, 5'b11011, 6'b0);
        repeat (3) @(negedge clk);
        // R1: reset state
        check_bit("R1 reset out_valid", out_valid, 1'b0);
        check_bit("R1 reset fault", prot_fault, 1'b0);
        check_bit("R1 reset err_code zero", err_code == '0, 1'b1);
        check_bit("R1 reset upd", leaf_upd | leaf_dirty, 1'b0);
        in_valid = 1'b0;
        rst_n    = 1'b1;

        // Vector table, one request at a time.
        for (int v = 0; v < N_VEC; v++) begin
            @(negedge clk);
            drive(int'(VEC[v][30:29]), int'(VEC[v][28:27]), int'(VEC[v][26:25]),
                  VEC[v][24:19], VEC[v][18:14], VEC[v][13:8]);
            in_valid = 1'b1;
            @(negedge clk);
            in_valid = 1'b0;
            check_bit("R1 one clock: no result yet", out_valid, 1'b0);
            @(negedge clk);
            check_bit("R1 two clocks: result valid", out_valid, 1'b1);
            check_result(int'(VEC[v][34:31]), VEC[v][7:0]);
        end

        // R10: idle cycles with changing inputs leave results alone (last was R8 vector).
        drive(1, 1, 0, 6'b000000, 5'b00000, 6'b111111);
        repeat (3) begin
            @(negedge clk);
            check_bit("R10 out_valid low when idle", out_valid, 1'b0);
            check_result(8, 8'b0_10100_0_0);
        end

        // Back-to-back sweep against the reference model (R2 to R9).
        for (int i = 0; i < N_SWEEP + 2; i++) begin
            @(negedge clk);
            if (i >= 2) begin
                int pp;
                pp = ((i - 2) / 4096 / 3) % 3;
                check_bit("R1 sweep out_valid", out_valid, 1'b1);
                check_result(pp == 0 ? 3 : (pp == 1 ? 4 : 5), exp_ring[(i - 2) % 3]);
            end
            if (i < N_SWEEP) begin
                logic [11:0] b;
                int r, a, p, k;
                logic [5:0] d, c;
                logic [4:0] t;
                b = 12'(i % 4096);
                r = i / 4096;
                a = r % 3; p = (r / 3) % 3; k = r / 9;
                d = {b[0], b[1], b[2], b[3], b[6], b[7]};
                t = {b[4], b[5], b[3] ^ b[8], b[6] ^ b[11], b[7] ^ b[10]};
                c = {b[8], b[9], b[10], b[11], b[0] ^ b[9], b[1] ^ b[10]};
                drive(a, p, k, d, t, c);
                in_valid = 1'b1;
                exp_ring[i % 3] = ref_eval(a, p, k, d, t, c);
            end else begin
                in_valid = 1'b0;
            end
        end

        // R1: reset in mid-run clears a faulting result.
        @(negedge clk);
        drive(1, 0, 0, 6'b100010, 5'b11011, 6'b0);
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        check_bit("R3 fault before reset", prot_fault, 1'b1);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check_bit("R1 mid-run reset fault", prot_fault, 1'b0);
        check_bit("R1 mid-run reset err_code zero", err_code == '0, 1'b1);
        check_bit("R1 mid-run reset out_valid", out_valid, 1'b0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule